// File: doc/BRIEF.md
# Transactional Conflict Event Monitor

This block sits beside one processor's transactional cache and profiles the events that cost a transaction its work. When a remote commit breaks a dependency, it writes a violation record. The record names the object address, the thread whose commit caused the break and the PC of the load that first read the line. It also holds the number of cycles the aborted transaction had run. When the speculative buffer overflows, the transaction keeps the commit token until it commits. The block then writes an overflow record with the PC at overflow, the overflow type and the number of cycles the token was held.

Each record carries an occurrence count for its kind. Records queue in a small FIFO that software drains with a read strobe. The FIFO head appears on the record outputs. If a record arrives while the FIFO is full and nothing is being popped, that newest record is discarded and a sticky lost flag is raised.

Top module: `txn_conflict_monitor`

## Requirements
- R1: After reset the FIFO is empty (`rec_valid` low) and `rec_lost` is low.
- R2: A violation while a transaction is open produces a record with `rec_kind`=0. The record holds the violation's object address and writer thread ID, with `rec_type`=0. A violation while no transaction is open is ignored.
- R3: The PC stored for a line is the PC of the first transactional load to that line in the current transaction. Later loads to the same line do not replace it. A new `tx_begin` forgets all lines, and a violation on a line not read in the current transaction reports PC 0.
- R4: A violation record's cycle field equals the number of rising edges from the edge that samples `tx_begin` to the edge that samples the violation. The violation closes the transaction, and the next transaction counts from zero.
- R5: Each violation record carries a violation count that starts at 1 and rises by one for every violation record produced, including records that are dropped.
- R6: An overflow that starts inside a transaction is held until commit. At that commit the block writes a record with `rec_kind`=1, the overflow PC, the 2-bit type, an overflow count that starts at 1, `rec_addr`=0 and `rec_tid`=0. Its cycle field is the number of edges from the edge that samples the overflow to the edge that samples commit.
- R7: Records leave the FIFO in arrival order. `rd_en` while a record is valid exposes the next one on the following cycle, and `rd_en` while empty has no effect.
- R8: With `DEPTH` records queued and no pop, a new record is discarded, the queued records are unchanged, and `rec_lost` goes high and stays high until reset.
- R9: A commit with no overflow pending closes the transaction without producing a record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_begin | input | 1 | Transaction start |
| commit | input | 1 | Transaction commit |
| ld_valid | input | 1 | Transactional load strobe |
| ld_line | input | LW | Cache line index of the load |
| ld_pc | input | PC_W | PC of the load |
| viol_valid | input | 1 | Dependency violation from a remote commit |
| viol_line | input | LW | Line index hit by the violation |
| viol_addr | input | ADDR_W | Object address of the violation |
| viol_tid | input | TID_W | Thread ID of the committing writer |
| ovf_valid | input | 1 | Speculative buffer overflow |
| ovf_pc | input | PC_W | PC at overflow |
| ovf_type | input | TYPE_W | Overflow type code |
| rd_en | input | 1 | Pop the FIFO head |
| rec_valid | output | 1 | FIFO head holds a record |
| rec_kind | output | 1 | 0 violation, 1 overflow |
| rec_addr | output | ADDR_W | Object address (violation) |
| rec_tid | output | TID_W | Writer thread ID (violation) |
| rec_type | output | TYPE_W | Overflow type (overflow) |
| rec_pc | output | PC_W | Read PC or overflow PC |
| rec_cycles | output | CYC_W | Wasted cycles or token-hold duration |
| rec_count | output | CNT_W | Occurrence count of this kind |
| rec_lost | output | 1 | Sticky: a record was dropped |

## Verification
The bench uses the default parameters: eight lines, a four-entry FIFO and 16-bit cycle and PC fields. With only four entries, a burst of five violations is enough to fill the FIFO and reach the drop-and-flag path. With eight lines, the bench can revisit a line that was read in an earlier transaction and check that its PC is no longer reported. The 16-bit counters never saturate in these short runs, so every cycle count is an exact edge count computed in the bench.

// File: rtl/txn_conflict_monitor.sv
module txn_conflict_monitor #(
  parameter int ADDR_W = 16,
  parameter int PC_W   = 16,
  parameter int TID_W  = 3,
  parameter int TYPE_W = 2,
  parameter int CYC_W  = 16,
  parameter int CNT_W  = 8,
  parameter int LINES  = 8,
  parameter int DEPTH  = 4,
  localparam int LW    = $clog2(LINES),
  localparam int PW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_begin,
  input  logic              commit,
  input  logic              ld_valid,
  input  logic [LW-1:0]     ld_line,
  input  logic [PC_W-1:0]   ld_pc,
  input  logic              viol_valid,
  input  logic [LW-1:0]     viol_line,
  input  logic [ADDR_W-1:0] viol_addr,
  input  logic [TID_W-1:0]  viol_tid,
  input  logic              ovf_valid,
  input  logic [PC_W-1:0]   ovf_pc,
  input  logic [TYPE_W-1:0] ovf_type,
  input  logic              rd_en,
  output logic              rec_valid,
  output logic              rec_kind,
  output logic [ADDR_W-1:0] rec_addr,
  output logic [TID_W-1:0]  rec_tid,
  output logic [TYPE_W-1:0] rec_type,
  output logic [PC_W-1:0]   rec_pc,
  output logic [CYC_W-1:0]  rec_cycles,
  output logic [CNT_W-1:0]  rec_count,
  output logic              rec_lost
);
  localparam int REC_W = 1 + ADDR_W + TID_W + TYPE_W + PC_W + CYC_W + CNT_W;

  logic              active, holding;
  logic [CYC_W-1:0]  cyc, dur;
  logic [LINES-1:0]  rd_set;
  logic [PC_W-1:0]   rd_pc [LINES];
  logic [PC_W-1:0]   opc;
  logic [TYPE_W-1:0] otype;
  logic [CNT_W-1:0]  vcnt, ocnt;

  logic [REC_W-1:0]  mem [DEPTH];
  logic [PW-1:0]     wp, rp;
  logic [PW:0]       cnt;

  logic do_viol, do_ovf, push, pop, full, wr;
  logic [CYC_W-1:0] cyc_inc, dur_inc;
  logic [PC_W-1:0]  hit_pc;
  logic [REC_W-1:0] new_rec;

  assign do_viol = viol_valid && active;
  assign do_ovf  = commit && holding && !do_viol;
  assign cyc_inc = (cyc == '1) ? cyc : cyc + 1'b1;
  assign dur_inc = (dur == '1) ? dur : dur + 1'b1;
  assign hit_pc  = rd_set[viol_line] ? rd_pc[viol_line] : '0;
  assign new_rec = do_viol
    ? {1'b0, viol_addr, viol_tid, {TYPE_W{1'b0}}, hit_pc, cyc_inc, vcnt + 1'b1}
    : {1'b1, {ADDR_W{1'b0}}, {TID_W{1'b0}}, otype, opc, dur_inc, ocnt + 1'b1};

  assign push = do_viol || do_ovf;
  assign full = (cnt == (PW+1)'(DEPTH));
  assign pop  = rd_en && (cnt != '0);
  assign wr   = push && (!full || pop);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      holding <= 1'b0;
      cyc     <= '0;
      dur     <= '0;
      rd_set  <= '0;
      opc     <= '0;
      otype   <= '0;
      vcnt    <= '0;
      ocnt    <= '0;
    end else begin
      if (active) cyc <= cyc_inc;
      if (holding) dur <= dur_inc;
      if (do_viol) begin
        active  <= 1'b0;
        holding <= 1'b0;
        cyc     <= '0;
        vcnt    <= vcnt + 1'b1;
      end else if (tx_begin) begin
        active  <= 1'b1;
        holding <= 1'b0;
        cyc     <= '0;
        rd_set  <= '0;
      end else if (commit) begin
        active  <= 1'b0;
        holding <= 1'b0;
        cyc     <= '0;
        if (holding) ocnt <= ocnt + 1'b1;
      end else begin
        if (ld_valid && active && !rd_set[ld_line]) begin
          rd_set[ld_line] <= 1'b1;
          rd_pc[ld_line]  <= ld_pc;
        end
        if (ovf_valid && active && !holding) begin
          holding <= 1'b1;
          dur     <= '0;
          opc     <= ovf_pc;
          otype   <= ovf_type;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp       <= '0;
      rp       <= '0;
      cnt      <= '0;
      rec_lost <= 1'b0;
    end else begin
      if (wr) begin
        mem[wp] <= new_rec;
        wp <= (wp == PW'(DEPTH-1)) ? '0 : wp + 1'b1;
      end
      if (pop) rp <= (rp == PW'(DEPTH-1)) ? '0 : rp + 1'b1;
      if (wr && !pop) cnt <= cnt + 1'b1;
      else if (pop && !wr) cnt <= cnt - 1'b1;
      if (push && !wr) rec_lost <= 1'b1;
    end
  end

  assign rec_valid = (cnt != '0);
  assign {rec_kind, rec_addr, rec_tid, rec_type, rec_pc, rec_cycles, rec_count} = mem[rp];

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= (PW+1)'(DEPTH)); // R8
  AST_LOST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    rec_lost |=> rec_lost); // R8
  AST_HOLD_IN_TXN: assert property (@(posedge clk) disable iff (!rst_n)
    holding |-> active); // R6
  AST_VIOL_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_valid && active) |=> (!active && cyc == '0)); // R4
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rec_valid && !viol_valid && !commit) |=> !rec_valid); // R7
  AST_IDLE_VIOL: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_valid && !active && !commit && !rd_en) |=> $stable(cnt)); // R2
endmodule

// File: tb/sim_txn_conflict_monitor.sv
module sim_txn_conflict_monitor;
  logic clk = 0, rst_n = 0;
  logic tx_begin = 0, commit = 0, ld_valid = 0, viol_valid = 0, ovf_valid = 0, rd_en = 0;
  logic [2:0] ld_line = 0, viol_line = 0, viol_tid = 0;
  logic [15:0] ld_pc = 0, viol_addr = 0, ovf_pc = 0;
  logic [1:0] ovf_type = 0;
  logic rec_valid, rec_kind, rec_lost;
  logic [15:0] rec_addr, rec_pc, rec_cycles;
  logic [2:0] rec_tid;
  logic [1:0] rec_type;
  logic [7:0] rec_count;
  int checks = 0, fails = 0, vexp = 0;
  bit done = 0;

  txn_conflict_monitor u0 (.*);

  always #5 clk = ~clk;

  // {line, pc, addr, tid, idle}
  localparam logic [41:0] VEC [4] = '{
    {3'd1, 16'h1A00, 16'h8040, 3'd2, 4'd0},
    {3'd5, 16'h2B10, 16'h00E4, 3'd7, 4'd3},
    {3'd0, 16'h3C20, 16'hFFF0, 3'd0, 4'd9},
    {3'd7, 16'h4D30, 16'h1234, 3'd4, 4'd1}
  };

  task automatic step(); @(posedge clk); #1; endtask

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic idle(int n); for (int k = 0; k < n; k++) step(); endtask

  task automatic pulse_begin(); tx_begin = 1; step(); tx_begin = 0; endtask
  task automatic pulse_commit(); commit = 1; step(); commit = 0; endtask
  task automatic pop(); rd_en = 1; step(); rd_en = 0; endtask
  task automatic load(logic [2:0] l, logic [15:0] p);
    ld_valid = 1; ld_line = l; ld_pc = p; step(); ld_valid = 0;
  endtask
  task automatic viol(logic [2:0] l, logic [15:0] a, logic [2:0] t);
    viol_valid = 1; viol_line = l; viol_addr = a; viol_tid = t; step(); viol_valid = 0;
  endtask

  initial begin
    idle(3);
    rst_n = 1;
    chk("R1 valid", rec_valid, 0);
    chk("R1 lost", rec_lost, 0);

    for (int i = 0; i < 4; i++) begin
      logic [41:0] v = VEC[i];
      pulse_begin();
      load(v[41:39], v[38:23]);
      load(v[41:39], ~v[38:23]);
      idle(int'(v[3:0]));
      viol(v[41:39], v[22:7], v[6:4]);
      vexp++;
      chk("R7 valid", rec_valid, 1);
      chk("R2 kind", rec_kind, 0);
      chk("R2 addr", rec_addr, v[22:7]);
      chk("R2 tid", rec_tid, v[6:4]);
      chk("R2 type", rec_type, 0);
      chk("R3 first pc", rec_pc, v[38:23]);
      chk("R4 cycles", rec_cycles, v[3:0] + 3);
      chk("R5 count", rec_count, vexp);
      pop();
      chk("R7 empty", rec_valid, 0);
    end

    pulse_begin();
    viol(3'd1, 16'h0101, 3'd3);
    vexp++;
    chk("R3 forgotten pc", rec_pc, 0);
    chk("R4 restart", rec_cycles, 1);
    pop();

    viol(3'd2, 16'h0202, 3'd1);
    chk("R2 idle ignored", rec_valid, 0);
    pulse_begin(); idle(2); pulse_commit();
    chk("R9 plain commit", rec_valid, 0);
    rd_en = 1; step(); rd_en = 0;
    chk("R7 empty pop", rec_valid, 0);

    for (int j = 0; j < 2; j++) begin
      pulse_begin();
      ovf_valid = 1; ovf_pc = 16'h5E00 + 16'(j); ovf_type = 2'(j + 1); step(); ovf_valid = 0;
      idle(4 + j);
      pulse_commit();
      chk("R6 kind", rec_kind, 1);
      chk("R6 pc", rec_pc, 16'h5E00 + 16'(j));
      chk("R6 type", rec_type, j + 1);
      chk("R6 addr", rec_addr, 0);
      chk("R6 duration", rec_cycles, 5 + j);
      chk("R6 count", rec_count, j + 1);
      pop();
    end

    for (int j = 0; j < 5; j++) begin
      pulse_begin();
      viol(3'd4, 16'hA000 + 16'(j), 3'd5);
      vexp++;
    end
    chk("R8 lost", rec_lost, 1);
    for (int j = 0; j < 4; j++) begin
      chk("R7 order addr", rec_addr, 16'hA000 + 16'(j));
      chk("R8 kept count", rec_count, vexp - 4 + j);
      pop();
    end
    chk("R8 newest dropped", rec_valid, 0);
    pulse_begin();
    viol(3'd4, 16'hB000, 3'd6);
    vexp++;
    chk("R5 count after drop", rec_count, vexp);
    chk("R8 lost sticky", rec_lost, 1);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule